// File: doc/BRIEF.md
# SerDes Lane Override Sequencer

This block puts a SerDes lane into a fixed receive and transmit override setup after a link reset. It does not touch the PHY directly. Instead it issues single-word read and write requests to an external indirect register access engine and completes each request on that engine's acknowledge. Every register address is formed from a per-lane base, so one sequencer can serve any lane of a multi-lane PHY.

An override command carries a lane number, a receive DPLL mode and a transmit attenuation code. The sequencer first polls the lane's receive status until the half-rate flag drops, with a bound on the number of extra reads. It then reads receive status and walks the receive override register through five writes: override bit cleared, override bit set, DPLL mode field replaced, DPLL reset raised, DPLL reset released. It then holds off for a settle interval. Unless the attenuation code carries its skip flag, it then reads transmit status and writes the transmit override three times: override bit cleared, override bit set, attenuation field merged in. A separate clear command only reads receive status and writes it back to the receive override with the override bit cleared. A lane marked as absent finishes any command at once without any access.

Top module: `serdes_lane_ovr_seq`

## Requirements
- R1: Register addresses are the lane number times 0x100 plus a fixed offset: receive status 0x2002, receive override 0x2005, transmit status 0x2001, transmit override 0x2004. Only the two override addresses are ever written.
- R2: An override command starts by reading receive status. While the value read has bit 0 set and fewer than POLL_MAX extra reads have been made, it reads again. It then reads receive status once more to get the working value.
- R3: The receive phase writes the receive override five times, in this order, each value derived from the one before: working value with bit 14 cleared; bit 14 set; bits 10:8 replaced by the 3-bit DPLL mode; bit 11 set; bit 11 cleared.
- R4: After the last receive write completes, no access is issued for SETTLE_CYCLES clock cycles.
- R5: The transmit phase reads transmit status and then writes the transmit override three times: the value with bit 15 cleared; bit 15 set; bits 2:0 of the attenuation code ORed into bits 12:10.
- R6: When bit 3 of the attenuation code is set, the transmit phase is skipped and the command ends after the settle interval.
- R7: A clear command reads receive status once and writes that value to the receive override with bit 14 cleared, then ends. If a start and a clear arrive in the same cycle, the override command is run.
- R8: If lane_absent is high when a command is accepted, done is high in the next cycle and no access request is made.
- R9: done is a single-cycle pulse in the cycle after the acknowledge of the last access (or after the settle interval when the transmit phase is skipped). busy is high from acceptance until done.
- R10: Start and clear inputs seen while busy are ignored. The running command's lane, mode and attenuation stay as latched at acceptance.
- R11: An access request keeps its address, direction and write data stable until it is acknowledged. A transfer completes in a cycle where acc_req and acc_ack are both high.
- R12: After reset the block is idle: busy, done and acc_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovr_start | input | 1 | Start the full override sequence |
| ovr_clear | input | 1 | Start the receive override clear |
| lane_sel | input | LANE_W | Lane the command applies to |
| lane_absent | input | 1 | Lane has no PHY behind it |
| dpll_mode | input | 3 | Receive DPLL mode value |
| tx_atten | input | 4 | Transmit attenuation; bit 3 skips the transmit phase |
| acc_req | output | 1 | Access request to the register engine |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_addr | output | 16 | Register address |
| acc_wdata | output | 16 | Write data |
| acc_rdata | input | 16 | Read data, valid with acc_ack on a read |
| acc_ack | input | 1 | Access completion |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every lane against all sixteen attenuation codes, with the number of half-rate reads rising past the poll bound. Each run's access trace is compared with a trace computed from the requirements. A design that ignores the poll bound loops on a stuck half-rate flag, and one that merges the mode field without masking or skips the reset pulse writes wrong values. A design that tests the wrong attenuation bit or drops the settle wait changes the trace or the gap before the transmit read. Commands issued mid-sequence, simultaneous start and clear, clear on every lane and absent lanes catch a sequencer that restarts, picks the wrong command, or touches the bus for a missing PHY.

// File: rtl/lane_ovr_pkg.sv
package lane_ovr_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int LANE_SH = 8;

  localparam logic [ADDR_W-1:0] RX_STAT_OFS = 16'h2002;
  localparam logic [ADDR_W-1:0] RX_OVR_OFS  = 16'h2005;
  localparam logic [ADDR_W-1:0] TX_STAT_OFS = 16'h2001;
  localparam logic [ADDR_W-1:0] TX_OVR_OFS  = 16'h2004;

  localparam int HALF_RATE_BIT = 0;
  localparam int RX_OVR_BIT    = 14;
  localparam int TX_OVR_BIT    = 15;
  localparam int DPLL_RST_BIT  = 11;
  localparam int DPLL_LSB      = 8;
  localparam int ATT_LSB       = 10;
  localparam int ATT_SKIP_BIT  = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL, ST_RX_RD, ST_RX_CLR, ST_RX_SET, ST_RX_MODE,
    ST_RX_RST, ST_RX_REL, ST_SETTLE, ST_TX_RD, ST_TX_CLR, ST_TX_SET,
    ST_TX_ATT, ST_DONE
  } seq_state_t;
endpackage

// File: rtl/lane_addr_map.sv
module lane_addr_map
  import lane_ovr_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  seq_state_t        state,
  input  logic [LANE_W-1:0] lane,
  output logic              req,
  output logic              wr,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] ofs;
  logic [ADDR_W-1:0] lane_base;

  assign lane_base = ADDR_W'(lane) << LANE_SH;

  always_comb begin
    req = 1'b1;
    wr  = 1'b0;
    ofs = RX_STAT_OFS;
    case (state)
      ST_POLL, ST_RX_RD: ofs = RX_STAT_OFS;
      ST_RX_CLR, ST_RX_SET, ST_RX_MODE, ST_RX_RST, ST_RX_REL: begin
        ofs = RX_OVR_OFS;
        wr  = 1'b1;
      end
      ST_TX_RD: ofs = TX_STAT_OFS;
      ST_TX_CLR, ST_TX_SET, ST_TX_ATT: begin
        ofs = TX_OVR_OFS;
        wr  = 1'b1;
      end
      default: req = 1'b0;
    endcase
  end

  assign addr = lane_base + ofs;
endmodule

// File: rtl/ovr_word_calc.sv
module ovr_word_calc
  import lane_ovr_pkg::*;
(
  input  seq_state_t        state,
  input  logic [DATA_W-1:0] cur,
  input  logic [2:0]        mode,
  input  logic [3:0]        atten,
  output logic [DATA_W-1:0] wdata
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'(7) << DPLL_LSB;

  always_comb begin
    case (state)
      ST_RX_CLR:  wdata = cur & ~(ONE << RX_OVR_BIT);
      ST_RX_SET:  wdata = cur | (ONE << RX_OVR_BIT);
      ST_RX_MODE: wdata = (cur & ~MODE_MASK) | (DATA_W'(mode) << DPLL_LSB);
      ST_RX_RST:  wdata = cur | (ONE << DPLL_RST_BIT);
      ST_RX_REL:  wdata = cur & ~(ONE << DPLL_RST_BIT);
      ST_TX_CLR:  wdata = cur & ~(ONE << TX_OVR_BIT);
      ST_TX_SET:  wdata = cur | (ONE << TX_OVR_BIT);
      ST_TX_ATT:  wdata = cur | (DATA_W'(atten[2:0]) << ATT_LSB);
      default:    wdata = '0;
    endcase
  end
endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | inc;
  assign cnt_d  = clr ? '0 : cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/serdes_lane_ovr_seq.sv
module serdes_lane_ovr_seq
  import lane_ovr_pkg::*;
#(
  parameter int LANE_W        = 2,
  parameter int POLL_MAX      = 1000,
  parameter int SETTLE_CYCLES = 15000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovr_start,
  input  logic              ovr_clear,
  input  logic [LANE_W-1:0] lane_sel,
  input  logic              lane_absent,
  input  logic [2:0]        dpll_mode,
  input  logic [3:0]        tx_atten,
  output logic              acc_req,
  output logic              acc_wr,
  output logic [15:0]       acc_addr,
  output logic [15:0]       acc_wdata,
  input  logic [15:0]       acc_rdata,
  input  logic              acc_ack,
  output logic              busy,
  output logic              done
);
  localparam int CNT_MAX = (POLL_MAX > SETTLE_CYCLES) ? POLL_MAX : SETTLE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] POLL_LIM   = CNT_W'(POLL_MAX);
  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_CYCLES - 1);

  seq_state_t        st_q, st_d;
  logic [LANE_W-1:0] lane_q;
  logic [2:0]        mode_q;
  logic [3:0]        att_q;
  logic              clr_cmd_q;
  logic              cmd_ld;
  logic [DATA_W-1:0] work_q, work_d;
  logic              work_en;
  logic              cnt_clr, cnt_inc;
  logic [CNT_W-1:0]  cnt;
  logic              xfer;

  lane_addr_map #(.LANE_W(LANE_W)) u_addr (
    .state(st_q), .lane(lane_q), .req(acc_req), .wr(acc_wr), .addr(acc_addr)
  );

  ovr_word_calc u_word (
    .state(st_q), .cur(work_q), .mode(mode_q), .atten(att_q), .wdata(acc_wdata)
  );

  step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  assign xfer    = acc_req & acc_ack;
  assign work_en = xfer;
  assign work_d  = acc_wr ? acc_wdata : acc_rdata;
  assign busy    = (st_q != ST_IDLE);
  assign done    = (st_q == ST_DONE);

  always_comb begin
    st_d    = st_q;
    cmd_ld  = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ovr_start | ovr_clear) begin
          cmd_ld = 1'b1;
          if (lane_absent) begin
            st_d = ST_DONE;
          end else if (ovr_start) begin
            st_d    = ST_POLL;
            cnt_clr = 1'b1;
          end else begin
            st_d = ST_RX_RD;
          end
        end
      end
      ST_POLL: begin
        if (xfer) begin
          if (acc_rdata[HALF_RATE_BIT] && (cnt < POLL_LIM)) cnt_inc = 1'b1;
          else                                              st_d = ST_RX_RD;
        end
      end
      ST_RX_RD:   if (xfer) st_d = ST_RX_CLR;
      ST_RX_CLR:  if (xfer) st_d = clr_cmd_q ? ST_DONE : ST_RX_SET;
      ST_RX_SET:  if (xfer) st_d = ST_RX_MODE;
      ST_RX_MODE: if (xfer) st_d = ST_RX_RST;
      ST_RX_RST:  if (xfer) st_d = ST_RX_REL;
      ST_RX_REL: begin
        if (xfer) begin
          st_d    = ST_SETTLE;
          cnt_clr = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cnt == SETTLE_END) st_d = att_q[ATT_SKIP_BIT] ? ST_DONE : ST_TX_RD;
        else                   cnt_inc = 1'b1;
      end
      ST_TX_RD:  if (xfer) st_d = ST_TX_CLR;
      ST_TX_CLR: if (xfer) st_d = ST_TX_SET;
      ST_TX_SET: if (xfer) st_d = ST_TX_ATT;
      ST_TX_ATT: if (xfer) st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q    <= '0;
      mode_q    <= '0;
      att_q     <= '0;
      clr_cmd_q <= 1'b0;
    end else if (cmd_ld) begin
      lane_q    <= lane_sel;
      mode_q    <= dpll_mode;
      att_q     <= tx_atten;
      clr_cmd_q <= ~ovr_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       work_q <= '0;
    else if (work_en) work_q <= work_d;
  end
endmodule

// File: rtl/serdes_lane_ovr_seq_chk.sv
module serdes_lane_ovr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ovr_start,
  input logic        lane_absent,
  input logic        acc_req,
  input logic        acc_wr,
  input logic [15:0] acc_addr,
  input logic [15:0] acc_wdata,
  input logic        acc_ack,
  input logic        busy,
  input logic        done
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_addr) && $stable(acc_wr) && $stable(acc_wdata));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  absent_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_start && !busy && lane_absent |=> done && !acc_req);

  // R1
  addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> (acc_addr[15:10] == 6'b001000) &&
                (acc_addr[7:0] == 8'h01 || acc_addr[7:0] == 8'h02 ||
                 acc_addr[7:0] == 8'h04 || acc_addr[7:0] == 8'h05));

  // R1
  write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_wr |-> (acc_addr[7:0] == 8'h04 || acc_addr[7:0] == 8'h05));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !acc_req);
endmodule

bind serdes_lane_ovr_seq serdes_lane_ovr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovr_start(ovr_start), .lane_absent(lane_absent),
  .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
  .acc_ack(acc_ack), .busy(busy), .done(done)
);

// File: tb/serdes_lane_ovr_seq_bench.sv
module serdes_lane_ovr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int POLL_MAX   = 4;
  localparam int SETTLE     = 12;
  localparam int LOG_N      = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovr_start = 1'b0, ovr_clear = 1'b0, lane_absent = 1'b0;
  logic [1:0]  lane_sel = '0;
  logic [2:0]  dpll_mode = '0;
  logic [3:0]  tx_atten = '0;
  logic        acc_req, acc_wr, acc_ack, busy, done;
  logic [15:0] acc_addr, acc_wdata, acc_rdata;

  int tests = 0, fails = 0;
  int hr_limit = 0;
  logic clr_log = 1'b0;
  int rx_reads, lg_n, cyc;
  logic        lg_wr [LOG_N];
  logic [15:0] lg_addr [LOG_N];
  logic [15:0] lg_data [LOG_N];
  int          lg_cyc [LOG_N];
  logic        ex_wr [LOG_N];
  logic [15:0] ex_addr [LOG_N];
  logic [15:0] ex_data [LOG_N];
  int ex_n, ex_rx_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  serdes_lane_ovr_seq #(.LANE_W(2), .POLL_MAX(POLL_MAX), .SETTLE_CYCLES(SETTLE))
    u_serdes_lane_ovr_seq (
    .clk(clk), .rst_n(rst_n), .ovr_start(ovr_start), .ovr_clear(ovr_clear),
    .lane_sel(lane_sel), .lane_absent(lane_absent), .dpll_mode(dpll_mode),
    .tx_atten(tx_atten), .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_ack(acc_ack),
    .busy(busy), .done(done)
  );

  function automatic logic [15:0] rx_base(input int lane);
    return 16'h4FF0 ^ 16'(lane << 12);
  endfunction
  function automatic logic [15:0] tx_base(input int lane);
    return 16'hA5A4 ^ 16'(lane << 12);
  endfunction

  // register engine model: one wait cycle per access
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_ack <= 1'b0;
    else        acc_ack <= acc_req && !acc_ack;
  end

  always_comb begin
    if (acc_addr[7:0] == 8'h02)
      acc_rdata = rx_base(int'(acc_addr[9:8])) | 16'(rx_reads < hr_limit);
    else if (acc_addr[7:0] == 8'h01)
      acc_rdata = tx_base(int'(acc_addr[9:8]));
    else
      acc_rdata = 16'h0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr_log) begin
      lg_n <= 0;
      rx_reads <= 0;
    end else if (acc_req && acc_ack) begin
      if (lg_n < LOG_N) begin
        lg_wr[lg_n]   <= acc_wr;
        lg_addr[lg_n] <= acc_addr;
        lg_data[lg_n] <= acc_wr ? acc_wdata : acc_rdata;
        lg_cyc[lg_n]  <= cyc;
        lg_n <= lg_n + 1;
      end
      if (!acc_wr && acc_addr[7:0] == 8'h02) rx_reads <= rx_reads + 1;
    end
  end

  initial begin
    cyc = 0; lg_n = 0; rx_reads = 0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic add_ex(input bit w, input int a, input int d);
    ex_wr[ex_n] = w; ex_addr[ex_n] = 16'(a); ex_data[ex_n] = 16'(d);
    ex_n++;
  endtask

  task automatic build_ex(input bit st, input int lane, input int mode,
                          input int att, input int hr, input bit absent);
    int k; logic [15:0] v, t; int lb;
    ex_n = 0; ex_rx_end = 0; lb = lane * 256;
    if (absent) return;
    k = 0;
    if (st) begin
      forever begin
        v = rx_base(lane) | 16'(k < hr);
        add_ex(0, lb + 'h2002, v);
        if (v[0] && k < POLL_MAX) k++;
        else break;
      end
      k++;
    end
    v = rx_base(lane) | 16'(k < hr);
    add_ex(0, lb + 'h2002, v);
    t = v & ~16'h4000; add_ex(1, lb + 'h2005, t);
    if (!st) return;
    t = t | 16'h4000; add_ex(1, lb + 'h2005, t);
    t = (t & ~16'h0700) | 16'(mode << 8); add_ex(1, lb + 'h2005, t);
    t = t | 16'h0800; add_ex(1, lb + 'h2005, t);
    t = t & ~16'h0800; add_ex(1, lb + 'h2005, t);
    ex_rx_end = ex_n;
    if (att[3]) return;
    add_ex(0, lb + 'h2001, tx_base(lane));
    t = tx_base(lane) & ~16'h8000; add_ex(1, lb + 'h2004, t);
    t = t | 16'h8000; add_ex(1, lb + 'h2004, t);
    t = t | 16'((att & 7) << 10); add_ex(1, lb + 'h2004, t);
  endtask

  task automatic run(input bit st, input bit cl, input int lane, input int mode,
                     input int att, input int hr, input bit absent,
                     input bit inject, input string tag);
    int w;
    @(negedge clk); clr_log = 1'b1; hr_limit = hr;
    @(negedge clk); clr_log = 1'b0;
    ovr_start = st; ovr_clear = cl; lane_sel = 2'(lane);
    dpll_mode = 3'(mode); tx_atten = 4'(att); lane_absent = absent;
    @(negedge clk);
    ovr_start = 1'b0; ovr_clear = 1'b0; lane_absent = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk);
      ovr_start = 1'b1; ovr_clear = 1'b1; lane_sel = 2'(lane ^ 1);
      dpll_mode = 3'(mode ^ 5); tx_atten = 4'(att ^ 9);
      @(negedge clk);
      ovr_start = 1'b0; ovr_clear = 1'b0;
    end
    w = 0;
    while (!done && w < 2000) begin
      @(negedge clk); w++;
    end
    chk(done, "R9", {tag, " done seen"}, int'(done), 1);
    if (absent) chk(w == 0, "R8", {tag, " done latency"}, w, 0);
    @(negedge clk);
    chk(!done && !busy, "R9", {tag, " done one cycle"}, int'(done), 0);
    build_ex(st, lane, mode, att, hr, absent);
    chk(lg_n == ex_n, tag, "access count", lg_n, ex_n);
    if (lg_n == ex_n) begin
      bit ok; int bad; ok = 1; bad = 0;
      for (int i = 0; i < ex_n; i++)
        if (ok && (lg_wr[i] != ex_wr[i] || lg_addr[i] != ex_addr[i] ||
                   lg_data[i] != ex_data[i])) begin
          ok = 0; bad = i;
        end
      chk(ok, tag, "trace entry addr/data", {lg_addr[bad], lg_data[bad]},
          {ex_addr[bad], ex_data[bad]});
      if (st && !absent && att < 8)
        chk(lg_cyc[ex_rx_end] - lg_cyc[ex_rx_end-1] >= SETTLE + 1, "R4",
            "settle gap", lg_cyc[ex_rx_end] - lg_cyc[ex_rx_end-1], SETTLE + 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !acc_req, "R12", "idle after reset",
        {busy, done, acc_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !acc_req, "R12", "idle after release",
        {busy, done, acc_req}, 0);

    // R1 R2 R3 R5 R6 sweep, R10 injected commands mid-run
    for (int ln = 0; ln < 4; ln++)
      for (int at = 0; at < 16; at++)
        run(1, 0, ln, (ln * 3 + at) % 8, at, (at + ln) % 7, 0, at == 5,
            (at >= 8) ? "R6 skip" : ((at == 5) ? "R10 busy" : "R1 R2 R3 R5"));

    // R7 clear command on each lane, with half-rate set on some
    for (int ln = 0; ln < 4; ln++)
      run(0, 1, ln, 0, 0, ln % 2, 0, 0, "R7 clear");
    // R7 start wins over simultaneous clear
    run(1, 1, 2, 6, 3, 2, 0, 0, "R7 priority");
    // R8 absent lane, both command kinds
    run(1, 0, 1, 3, 2, 0, 1, 0, "R8 absent start");
    run(0, 1, 3, 0, 0, 0, 1, 0, "R8 absent clear");
    // R2 poll bound with half-rate stuck high
    run(1, 0, 0, 3, 1, 50, 0, 0, "R2 stuck");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule